// File: doc/BRIEF.md
# Multiplexed Microcontroller Bus Front End

This block lets a peripheral sit on the external bus of an 8-bit microcontroller that has a 16-bit address space and time-shares its low address byte with the 8 data lines. Configuration inputs select one of two bus styles. In the split-strobe style the host uses separate active-low read, write and program-fetch strobes and an active-high address latch pulse. In the enable-clock style the host uses an enable clock, a read/not-write line and an address strobe.

Every bus pin and the shared lines pass through two-flop synchronizers into the internal clock domain. From there the block captures the low address byte when the address phase ends and takes the high byte from its dedicated lines. It turns bus cycles into single-cycle internal read and write pulses, and it reports whether a read was a code fetch in a separate code space. It returns the peripheral's read data onto the shared lines only while a read is in progress. The external reset is mapped to an internal active-low reset by a polarity input. That reset asserts at once and is released through a synchronizer.

Each bus phase must last at least four internal clock periods, because control pins and bus lines are sampled with the same synchronizer depth.

Top module: `mux_bus_front`

## Requirements
- R1: `rstN` is low while the external reset is asserted. The reset is asserted when `extReset` equals `cfgRstHigh`. `rstN` goes high on the second rising clock edge after release. While `rstN` is low, `adBusOe`, `rdPulse` and `wrPulse` are 0 and `addr` is 0.
- R2: When `ale` falls, `addr[7:0]` takes the value on `adBusIn` and holds it until the next falling `ale`. `addr[15:8]` follows `adHi`.
- R3: In split style (`cfgStyle`=0), pulling `rdN` low gives exactly one `rdPulse`. The pulse is high after the third rising edge counted from the edge that first sees the strobe, with `codeFlag`=0.
- R4: In split style, pulling `psenN` low gives one `rdPulse`. `codeFlag` is 1 when `cfgCombined`=0 and 0 when `cfgCombined`=1. `codeFlag` changes only together with `rdPulse`.
- R5: In split style, a low period on `wrN` gives one `wrPulse` after `wrN` returns high. `wrData` then holds the value that was on `adBusIn` during the strobe. `wrData` changes only together with `wrPulse`.
- R6: In enable-clock style (`cfgStyle`=1), `eClk` high with `rnw`=1 gives exactly one `rdPulse` with `codeFlag`=0.
- R7: In enable-clock style, `eClk` high with `rnw`=0 gives one `wrPulse` after `eClk` falls. `wrData` then holds the value on `adBusIn` during the high phase.
- R8: `adBusOe` is 1 only while a read or fetch is active both at the pins and after synchronization. It drops in the same time step the strobe is released. `adBusOut` equals `rdData`.
- R9: The pins of the unselected style are ignored. In split style `eClk` and `rnw` are ignored. In enable style `rdN`, `wrN` and `psenN` are ignored. Activity on ignored pins produces no pulse and no bus drive.
- R10: A strobe held active for many cycles still gives only one single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| extReset | input | 1 | External reset, polarity set by cfgRstHigh |
| cfgRstHigh | input | 1 | 1: external reset active high, 0: active low |
| cfgStyle | input | 1 | 0: split strobes, 1: enable clock with read/not-write |
| cfgCombined | input | 1 | 1: code fetches go to the data space |
| ale | input | 1 | Address latch / address strobe, active high |
| rdN | input | 1 | Data read strobe, active low (split style) |
| wrN | input | 1 | Data write strobe, active low (split style) |
| psenN | input | 1 | Program fetch strobe, active low (split style) |
| eClk | input | 1 | Bus enable clock (enable style) |
| rnw | input | 1 | 1 read, 0 write (enable style) |
| adHi | input | 8 | High address byte lines |
| adBusIn | input | 8 | Shared address/data lines, input side |
| rdData | input | 8 | Read data from the peripheral |
| adBusOut | output | 8 | Shared lines, output side |
| adBusOe | output | 1 | Drive enable for the shared lines |
| addr | output | 16 | Latched bus address |
| rdPulse | output | 1 | One-cycle internal read pulse |
| wrPulse | output | 1 | One-cycle internal write pulse |
| codeFlag | output | 1 | Last read was from a separate code space |
| wrData | output | 8 | Captured write data |
| rstN | output | 1 | Conditioned internal reset, active low |

## Verification
A stale edge-detector register would show up as a missing or doubled pulse, or a pulse one cycle off its expected edge, within three clocks of a strobe change. A wrong address or data capture register would show a bad `addr` or `wrData` in the cycle after the pulse, and that value stays wrong until the next bus cycle. A wrong decode of style or space would give a wrong `codeFlag`, or pulses caused by pins that should be ignored, in the same bus cycle. Bus drive faults are seen at once on `adBusOe` around strobe edges.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  typedef enum logic {
    STYLE_SPLIT = 1'b0,
    STYLE_ECLK  = 1'b1
  } busStyle_e;

  typedef struct packed {
    logic ale;
    logic rdN;
    logic wrN;
    logic psenN;
    logic eClk;
    logic rnw;
  } busPins_t;

  typedef struct packed {
    logic addrPhase;
    logic readAct;
    logic writeAct;
    logic codeAct;
  } busLevels_t;

  typedef struct packed {
    logic capAddr;
    logic rdFire;
    logic wrFire;
    logic codeSel;
  } ctrlStrobes_t;

  localparam busPins_t PINS_IDLE = '{ale: 1'b0, rdN: 1'b1, wrN: 1'b1,
                                     psenN: 1'b1, eClk: 1'b0, rnw: 1'b1};

  function automatic busLevels_t decodePins(busStyle_e style, busPins_t p);
    busLevels_t l;
    l = '0;
    l.addrPhase = p.ale;
    if (style == STYLE_SPLIT) begin
      l.readAct  = ~p.rdN | ~p.psenN;
      l.codeAct  = ~p.psenN;
      l.writeAct = ~p.wrN;
    end else begin
      l.readAct  = p.eClk & p.rnw;
      l.writeAct = p.eClk & ~p.rnw;
    end
    return l;
  endfunction

endpackage

// File: rtl/sync_stages.sv
module sync_stages #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= {STAGES{RST_VAL}};
    else       stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rst_cond.sv
module rst_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic extReset,
  input  logic cfgRstHigh,
  output logic rstN
);
  logic rstAct;
  logic [STAGES-1:0] relChain;

  assign rstAct = cfgRstHigh ? extReset : ~extReset;

  always_ff @(posedge clk or posedge rstAct) begin
    if (rstAct) relChain <= '0;
    else        relChain <= {relChain[STAGES-2:0], 1'b1};
  end

  assign rstN = relChain[STAGES-1];
endmodule

// File: rtl/bus_ctrl.sv
module bus_ctrl
  import mux_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  busStyle_e    style,
  input  logic         combined,
  input  busPins_t     pinsRaw,
  output ctrlStrobes_t strobes,
  output logic         driveOk
);
  localparam int PIN_W = $bits(busPins_t);

  logic [PIN_W-1:0] pinsSyncVec;
  busPins_t   pinsSync;
  busLevels_t lvlSync;
  busLevels_t lvlRaw;
  logic alePrev, readPrev, writePrev;

  sync_stages #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_pinSync (
    .clk(clk), .rstN(rstN), .d(pinsRaw), .q(pinsSyncVec)
  );

  assign pinsSync = busPins_t'(pinsSyncVec);
  assign lvlSync  = decodePins(style, pinsSync);
  assign lvlRaw   = decodePins(style, pinsRaw);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alePrev   <= 1'b0;
      readPrev  <= 1'b0;
      writePrev <= 1'b0;
    end else begin
      alePrev   <= lvlSync.addrPhase;
      readPrev  <= lvlSync.readAct;
      writePrev <= lvlSync.writeAct;
    end
  end

  always_comb begin
    strobes.capAddr = alePrev & ~lvlSync.addrPhase;
    strobes.rdFire  = lvlSync.readAct & ~readPrev;
    strobes.wrFire  = writePrev & ~lvlSync.writeAct;
    strobes.codeSel = lvlSync.codeAct & ~combined;
  end

  assign driveOk = lvlSync.readAct & lvlRaw.readAct;
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import mux_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic                 driveOk,
  input  logic [DATA_W-1:0]    busIn,
  input  logic [HI_W-1:0]      hiIn,
  input  logic [DATA_W-1:0]    rdData,
  output logic [DATA_W-1:0]    busOut,
  output logic                 busOe,
  output logic [HI_W+DATA_W-1:0] addr,
  output logic [DATA_W-1:0]    wrData,
  output logic                 rdPulse,
  output logic                 wrPulse,
  output logic                 codeFlag
);
  logic [DATA_W-1:0] busSync;
  logic [HI_W-1:0]   hiSync;
  logic [DATA_W-1:0] loQ;

  sync_stages #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_busSync (
    .clk(clk), .rstN(rstN), .d(busIn), .q(busSync)
  );

  sync_stages #(.WIDTH(HI_W), .STAGES(SYNC_STAGES)) u_hiSync (
    .clk(clk), .rstN(rstN), .d(hiIn), .q(hiSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ      <= '0;
      wrData   <= '0;
      rdPulse  <= 1'b0;
      wrPulse  <= 1'b0;
      codeFlag <= 1'b0;
    end else begin
      rdPulse <= strobes.rdFire;
      wrPulse <= strobes.wrFire;
      if (strobes.capAddr) loQ <= busSync;
      if (strobes.wrFire)  wrData <= busSync;
      if (strobes.rdFire)  codeFlag <= strobes.codeSel;
    end
  end

  assign addr   = {hiSync, loQ};
  assign busOut = rdData;
  assign busOe  = driveOk;
endmodule

// File: rtl/mux_bus_front.sv
module mux_bus_front
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              extReset,
  input  logic              cfgRstHigh,
  input  logic              cfgStyle,
  input  logic              cfgCombined,
  input  logic              ale,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              psenN,
  input  logic              eClk,
  input  logic              rnw,
  input  logic [ADDR_W-DATA_W-1:0] adHi,
  input  logic [DATA_W-1:0] adBusIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] adBusOut,
  output logic              adBusOe,
  output logic [ADDR_W-1:0] addr,
  output logic              rdPulse,
  output logic              wrPulse,
  output logic              codeFlag,
  output logic [DATA_W-1:0] wrData,
  output logic              rstN
);
  localparam int HI_W = ADDR_W - DATA_W;

  busPins_t     pinsRaw;
  ctrlStrobes_t strobes;
  logic         driveOk;

  assign pinsRaw = '{ale: ale, rdN: rdN, wrN: wrN, psenN: psenN, eClk: eClk, rnw: rnw};

  rst_cond #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .extReset(extReset), .cfgRstHigh(cfgRstHigh), .rstN(rstN)
  );

  bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .style(busStyle_e'(cfgStyle)), .combined(cfgCombined),
    .pinsRaw(pinsRaw), .strobes(strobes), .driveOk(driveOk)
  );

  bus_datapath #(.DATA_W(DATA_W), .HI_W(HI_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .driveOk(driveOk),
    .busIn(adBusIn), .hiIn(adHi), .rdData(rdData),
    .busOut(adBusOut), .busOe(adBusOe), .addr(addr), .wrData(wrData),
    .rdPulse(rdPulse), .wrPulse(wrPulse), .codeFlag(codeFlag)
  );
endmodule

// File: rtl/mux_bus_front_chk.sv
module mux_bus_front_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdPulse,
  input logic          wrPulse,
  input logic          codeFlag,
  input logic          busOe,
  input logic          capAddr,
  input logic [DW-1:0] wrData,
  input logic [DW-1:0] addrLo
);
  p_rst_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (!rdPulse && !wrPulse && !busOe));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(capAddr) |-> $stable(addrLo));

  p_code_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdPulse |-> $stable(codeFlag));

  p_wdata_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wrPulse |-> $stable(wrData));

  p_rd_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdPulse |=> !rdPulse);

  p_wr_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);
endmodule

bind mux_bus_front mux_bus_front_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rdPulse(rdPulse), .wrPulse(wrPulse),
  .codeFlag(codeFlag), .busOe(adBusOe), .capAddr(strobes.capAddr),
  .wrData(wrData), .addrLo(addr[DATA_W-1:0])
);

// File: tb/mux_bus_front_tb.sv
module mux_bus_front_tb;
  logic clk = 1'b0;
  logic extReset = 1'b1, cfgRstHigh = 1'b1, cfgStyle = 1'b0, cfgCombined = 1'b0;
  logic ale = 1'b0, rdN = 1'b1, wrN = 1'b1, psenN = 1'b1, eClk = 1'b0, rnw = 1'b1;
  logic [7:0] adHi = '0, adBusIn = '0, rdData = '0;
  logic [7:0] adBusOut, wrData;
  logic [15:0] addr;
  logic adBusOe, rdPulse, wrPulse, codeFlag, rstN;

  int checks = 0, fails = 0;
  int rdCnt = 0, wrCnt = 0;
  logic codeSeen;
  logic [7:0] wrSeen;

  always #2.5 clk = ~clk;

  mux_bus_front u_dut (
    .clk(clk), .extReset(extReset), .cfgRstHigh(cfgRstHigh), .cfgStyle(cfgStyle),
    .cfgCombined(cfgCombined), .ale(ale), .rdN(rdN), .wrN(wrN), .psenN(psenN),
    .eClk(eClk), .rnw(rnw), .adHi(adHi), .adBusIn(adBusIn), .rdData(rdData),
    .adBusOut(adBusOut), .adBusOe(adBusOe), .addr(addr), .rdPulse(rdPulse),
    .wrPulse(wrPulse), .codeFlag(codeFlag), .wrData(wrData), .rstN(rstN)
  );

  always @(negedge clk) begin
    if (rdPulse) begin rdCnt++; codeSeen = codeFlag; end
    if (wrPulse) begin wrCnt++; wrSeen = wrData; end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit expCode(bit style, bit comb, int op);
    return (style == 1'b0) && (op == 1) && !comb;
  endfunction

  task automatic setStyle(bit s, bit comb);
    cfgStyle = s;
    cfgRstHigh = (s == 1'b0);
    extReset = (s == 1'b0) ? 1'b0 : 1'b1;
    cfgCombined = comb;
    waitCyc(5);
  endtask

  task automatic idlePins();
    rdN = 1'b1; wrN = 1'b1; psenN = 1'b1; eClk = 1'b0;
  endtask

  // op: 0 data read, 1 code fetch (split style), 2 write
  task automatic busCycle(int op, logic [7:0] hi, logic [7:0] lo, logic [7:0] dat, logic [7:0] rdv);
    string rq;
    rdCnt = 0; wrCnt = 0;
    adHi = hi; adBusIn = lo; rdData = rdv; ale = 1'b1;
    waitCyc(4);
    ale = 1'b0;
    waitCyc(4);
    adBusIn = (op == 2) ? dat : ~lo;
    if (cfgStyle == 1'b0) begin
      if (op == 0) rdN = 1'b0;
      else if (op == 1) psenN = 1'b0;
      else wrN = 1'b0;
    end else begin
      rnw = (op != 2);
      waitCyc(1);
      eClk = 1'b1;
    end
    waitCyc(5);
    if (op != 2) chk(adBusOe === 1'b1 && adBusOut === rdv, "R8 drive during read", {adBusOe, adBusOut}, {1'b1, rdv});
    idlePins();
    #1;
    if (op != 2) chk(adBusOe === 1'b0, "R8 release at strobe end", adBusOe, 0);
    waitCyc(6);
    rnw = 1'b1;
    chk(addr === {hi, lo}, "R2 address capture", addr, {hi, lo});
    if (op != 2) begin
      rq = (cfgStyle == 1'b0) ? ((op == 1) ? "R4 fetch pulse" : "R3 read pulse") : "R6 read pulse";
      chk(rdCnt == 1 && wrCnt == 0, rq, rdCnt * 16 + wrCnt, 16);
      chk(codeSeen === expCode(cfgStyle, cfgCombined, op), "R4 codeFlag", codeSeen,
          expCode(cfgStyle, cfgCombined, op));
    end else begin
      rq = (cfgStyle == 1'b0) ? "R5 write" : "R7 write";
      chk(wrCnt == 1 && rdCnt == 0, rq, wrCnt * 16 + rdCnt, 16);
      chk(wrSeen === dat, rq, wrSeen, dat);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset, active-high polarity
    waitCyc(3);
    chk(rstN === 1'b0 && adBusOe === 1'b0 && addr === 16'h0, "R1 reset state", {rstN, adBusOe, addr}, 0);
    chk(rdPulse === 1'b0 && wrPulse === 1'b0, "R1 pulses low", {rdPulse, wrPulse}, 0);
    extReset = 1'b0;
    @(posedge clk); #1;
    chk(rstN === 1'b0, "R1 release edge 1", rstN, 0);
    @(posedge clk); #1;
    chk(rstN === 1'b1, "R1 release edge 2", rstN, 1);
    waitCyc(3);

    // R3 directed latency
    rdCnt = 0;
    rdN = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk(rdPulse === 1'b0, "R3 latency early", rdPulse, 0);
    @(posedge clk); #1;
    chk(rdPulse === 1'b1, "R3 latency third edge", rdPulse, 1);
    // R10 long strobe, single pulse
    waitCyc(20);
    rdN = 1'b1;
    waitCyc(6);
    chk(rdCnt == 1, "R10 long strobe single pulse", rdCnt, 1);

    // directed cycles, split style, both space settings
    busCycle(0, 8'h12, 8'h34, 8'h00, 8'hA5);
    busCycle(1, 8'hFF, 8'h00, 8'h00, 8'h5A);
    busCycle(2, 8'h80, 8'h01, 8'hC3, 8'h00);
    setStyle(1'b0, 1'b1);
    busCycle(1, 8'h00, 8'hFF, 8'h00, 8'h3C);

    // R9 enable-style pins ignored in split style
    rdCnt = 0; wrCnt = 0;
    rnw = 1'b0; eClk = 1'b1; waitCyc(6);
    chk(adBusOe === 1'b0, "R9 split ignores eClk drive", adBusOe, 0);
    rnw = 1'b1; waitCyc(6); eClk = 1'b0; rnw = 1'b1; waitCyc(6);
    chk(rdCnt == 0 && wrCnt == 0, "R9 split ignores eClk/rnw", rdCnt + wrCnt, 0);

    // enable-clock style with active-low reset
    setStyle(1'b1, 1'b0);
    chk(rstN === 1'b1, "R1 active-low idle", rstN, 1);
    busCycle(0, 8'h5A, 8'hA5, 8'h00, 8'h77);
    busCycle(2, 8'h01, 8'h02, 8'h99, 8'h00);
    rdCnt = 0; wrCnt = 0;
    rdN = 1'b0; psenN = 1'b0; waitCyc(6);
    chk(adBusOe === 1'b0, "R9 eclk ignores rdN drive", adBusOe, 0);
    rdN = 1'b1; psenN = 1'b1; wrN = 1'b0; waitCyc(6); wrN = 1'b1; waitCyc(6);
    chk(rdCnt == 0 && wrCnt == 0, "R9 eclk ignores split strobes", rdCnt + wrCnt, 0);
    extReset = 1'b0; #1;
    chk(rstN === 1'b0 && adBusOe === 1'b0, "R1 active-low assert", rstN, 0);
    waitCyc(2);
    extReset = 1'b1;
    waitCyc(4);
    chk(addr === 16'h0 || addr[7:0] === 8'h0, "R1 addr cleared", addr[7:0], 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      bit s, c;
      int op;
      s = 1'($urandom % 2);
      c = 1'($urandom % 2);
      op = int'($urandom % 3);
      if (s == 1'b1 && op == 1) op = 0;
      setStyle(s, c);
      busCycle(op, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule